// File: doc/BRIEF.md
# Clock Compensation Elastic Buffer

This block sits between a recovered receive clock and a local core clock and absorbs the small, slow frequency offset between them. Words enter on the write clock every cycle and leave on the read clock every cycle. The buffer keeps its fill level near the middle. It drops a configurable skip symbol on the write side when the buffer runs high. It repeats a skip on the read side when the buffer runs low.

Each word carries two byte lanes, and each lane has a control flag. In single-width operation only the lower lane carries a symbol. In double-width operation both lanes are used, and skips are removed or added only as whole upper/lower pairs. The skip byte, the control flag value that marks a skip, and the width mode are static configuration inputs. They are changed only while both resets are held. Pulse outputs report each insertion and each deletion. Sticky flags record an overflow or an underflow.

Top module: `clock_comp_ebuf`

## Requirements
- R1: After reset, `rd_valid` stays low until the read side has seen at least START_LVL (default 10) words in the buffer. Only then does reading begin.
- R2: Every word that is not a skip leaves the read side exactly once, in write order, with no loss and no duplication, as long as no overflow occurs.
- R3: In single-width mode a lower-lane skip is dropped when the write-side fill is at or above HI_TH (default 14). Any number of skips in a cluster may be dropped, and `del_pulse` is high for the write cycle after each drop.
- R4: In double-width mode a word is dropped only when both lanes are skips. A word in which only one lane is a skip is always stored.
- R5: When the read-side fill is at or below LO_TH (default 6) and the previous output word was a skip, the block may output a skip without advancing the buffer. `ins_pulse` is high with that output word. An insertion never follows a non-skip output.
- R6: In single-width mode an insertion never makes a run of consecutive skip outputs longer than MAX_RUN (default 5).
- R7: In double-width mode an inserted word has the skip in both lanes.
- R8: `ovf_flag` sets when a non-skip word arrives while the write side sees the buffer completely full (20 words). The flag stays set until write reset.
- R9: `unf_flag` sets when the read side, once started, has nothing to output and cannot insert. `rd_valid` is low in that cycle, and the flag stays set until read reset.
- R10: In single-width mode the upper lane of `rd_data` (bits 17:9) is always zero.
- R11: Reset clears `rd_valid`, `ins_pulse`, `del_pulse`, `ovf_flag` and `unf_flag`.
- R12: A lane is a skip only if its byte equals `cfg_skip_sym` and its flag equals `cfg_skip_ctl`. A lane with the skip byte but the other flag value is treated as data. Word layout: bits 17:9 form the upper lane and bits 8:0 the lower lane. In each lane, the top bit is the control flag and the low 8 bits are the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered write clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_data | input | 18 | Incoming word, sampled every write cycle |
| rd_clk | input | 1 | Local read clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_data | output | 18 | Outgoing word |
| rd_valid | output | 1 | `rd_data` carries a word this cycle |
| cfg_double | input | 1 | 1 selects double-width pairs, 0 selects single-width |
| cfg_skip_sym | input | 8 | Skip byte value |
| cfg_skip_ctl | input | 1 | Control flag value that marks a skip |
| ins_pulse | output | 1 | Current output word is an inserted skip |
| del_pulse | output | 1 | A skip was dropped on the previous write cycle |
| ovf_flag | output | 1 | Sticky overflow, write domain |
| unf_flag | output | 1 | Sticky underflow, read domain |

## Verification
The bench builds the block with its default depth of 20 and thresholds of 6, 10 and 14. It runs the read clock 5% fast, then 5% slow, against a 50 MHz write clock, which is far outside the real tolerance. At that offset both thresholds are reached within a few hundred cycles instead of millions, so insertion, deletion and the five-skip cap are all exercised in each width mode. Two extra runs use read clocks at half and at twice the write rate with a skip-free stream. These drive the buffer to completely full and to empty, which exercises both sticky flags.

// File: rtl/ccbuf_pkg.sv
`timescale 1ns/1ps
package ccbuf_pkg;

    typedef struct packed {
        logic       k;
        logic [7:0] d;
    } lane_t;

    typedef struct packed {
        lane_t hi;
        lane_t lo;
    } word_t;

    localparam int WORD_W = $bits(word_t);

    typedef enum logic [1:0] {
        WA_STORE,
        WA_DROP_SKIP,
        WA_REJECT
    } wr_act_e;

    typedef enum logic [1:0] {
        RA_WAIT,
        RA_POP,
        RA_INSERT,
        RA_STARVE
    } rd_act_e;

    function automatic logic lane_is_skip(input lane_t l, input logic [7:0] sym,
                                          input logic ctl);
        return (l.d == sym) && (l.k == ctl);
    endfunction

    function automatic logic word_is_skip(input word_t w, input logic dbl,
                                          input logic [7:0] sym, input logic ctl);
        if (dbl)
            return lane_is_skip(w.hi, sym, ctl) && lane_is_skip(w.lo, sym, ctl);
        return lane_is_skip(w.lo, sym, ctl);
    endfunction

    function automatic word_t make_skip(input logic dbl, input logic [7:0] sym,
                                        input logic ctl);
        word_t w;
        w.lo.k = ctl;
        w.lo.d = sym;
        w.hi   = dbl ? w.lo : '0;
        return w;
    endfunction

endpackage

// File: rtl/ccbuf_ptr_sync.sv
`timescale 1ns/1ps
module ccbuf_ptr_sync #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= gray_in;
            stage2 <= stage1;
        end
    end

    always_comb begin
        logic [W-1:0] acc;
        acc[W-1] = stage2[W-1];
        for (int i = W - 2; i >= 0; i--)
            acc[i] = acc[i+1] ^ stage2[i];
        bin_out = acc;
    end
endmodule

// File: rtl/ccbuf_store.sv
`timescale 1ns/1ps
module ccbuf_store
    import ccbuf_pkg::*;
#(
    parameter int DEPTH = 20,
    parameter int AW    = 5
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);
    word_t mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ccbuf_wr_ctrl.sv
`timescale 1ns/1ps
module ccbuf_wr_ctrl
    import ccbuf_pkg::*;
#(
    parameter int DEPTH = 20,
    parameter int HI_TH = 14,
    parameter int AW    = 5,
    parameter int PW    = 6
) (
    input  logic          wr_clk,
    input  logic          wr_rst,
    input  word_t         in_word,
    input  logic          cfg_double,
    input  logic [7:0]    cfg_skip_sym,
    input  logic          cfg_skip_ctl,
    input  logic [PW-1:0] rptr_bin,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output logic          del_pulse,
    output logic          ovf_flag
);
    localparam logic [PW-1:0] HI_LVL    = PW'(HI_TH);
    localparam logic [PW-1:0] FULL_LVL  = PW'(DEPTH);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_nxt;
    logic [PW-1:0] fill;
    logic          is_skip;
    wr_act_e       act;

    assign fill    = wbin - rptr_bin;
    assign is_skip = word_is_skip(in_word, cfg_double, cfg_skip_sym, cfg_skip_ctl);

    always_comb begin
        if (is_skip && fill >= HI_LVL)
            act = WA_DROP_SKIP;
        else if (fill >= FULL_LVL)
            act = WA_REJECT;
        else
            act = WA_STORE;
    end

    assign we       = !wr_rst && (act == WA_STORE);
    assign wbin_nxt = wbin + PW'(1);

    always_ff @(posedge wr_clk) begin
        if (wr_rst) begin
            wbin      <= '0;
            wgray     <= '0;
            waddr     <= '0;
            del_pulse <= 1'b0;
            ovf_flag  <= 1'b0;
        end else begin
            del_pulse <= (act == WA_DROP_SKIP);
            if (act == WA_REJECT)
                ovf_flag <= 1'b1;
            if (act == WA_STORE) begin
                wbin  <= wbin_nxt;
                wgray <= wbin_nxt ^ (wbin_nxt >> 1);
                waddr <= (waddr == LAST_ADDR) ? '0 : waddr + AW'(1);
            end
        end
    end
endmodule

// File: rtl/ccbuf_rd_ctrl.sv
`timescale 1ns/1ps
module ccbuf_rd_ctrl
    import ccbuf_pkg::*;
#(
    parameter int LO_TH     = 6,
    parameter int START_LVL = 10,
    parameter int MAX_RUN   = 5,
    parameter int DEPTH     = 20,
    parameter int AW        = 5,
    parameter int PW        = 6,
    parameter int RW        = 3
) (
    input  logic          rd_clk,
    input  logic          rd_rst,
    input  logic          cfg_double,
    input  logic [7:0]    cfg_skip_sym,
    input  logic          cfg_skip_ctl,
    input  logic [PW-1:0] wptr_bin,
    input  word_t         head,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray,
    output word_t         out_word,
    output logic          out_valid,
    output logic          ins_pulse,
    output logic          unf_flag
);
    localparam logic [PW-1:0] LO_LVL    = PW'(LO_TH);
    localparam logic [PW-1:0] START_V   = PW'(START_LVL);
    localparam logic [RW-1:0] RUN_CAP   = RW'(MAX_RUN);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    logic [PW-1:0] rbin;
    logic [PW-1:0] rbin_nxt;
    logic [PW-1:0] fill;
    logic          primed;
    logic          last_skip;
    logic [RW-1:0] run_len;
    logic          ins_ok;
    rd_act_e       act;
    word_t         head_m;
    word_t         nxt_word;
    logic          nxt_valid;
    logic          nxt_skip;

    assign fill   = wptr_bin - rbin;
    assign ins_ok = (fill <= LO_LVL) && last_skip && (cfg_double || run_len < RUN_CAP);

    always_comb begin
        if (!primed)
            act = RA_WAIT;
        else if (ins_ok)
            act = RA_INSERT;
        else if (fill != '0)
            act = RA_POP;
        else
            act = RA_STARVE;
    end

    always_comb begin
        head_m = head;
        if (!cfg_double)
            head_m.hi = '0;
    end

    assign nxt_word  = (act == RA_INSERT) ? make_skip(cfg_double, cfg_skip_sym, cfg_skip_ctl)
                                          : head_m;
    assign nxt_valid = (act == RA_INSERT) || (act == RA_POP);
    assign nxt_skip  = nxt_valid && word_is_skip(nxt_word, cfg_double, cfg_skip_sym, cfg_skip_ctl);
    assign rbin_nxt  = rbin + PW'(1);

    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            rbin      <= '0;
            rgray     <= '0;
            raddr     <= '0;
            primed    <= 1'b0;
            last_skip <= 1'b0;
            run_len   <= '0;
            out_word  <= '0;
            out_valid <= 1'b0;
            ins_pulse <= 1'b0;
            unf_flag  <= 1'b0;
        end else begin
            if (!primed && fill >= START_V)
                primed <= 1'b1;
            out_word  <= nxt_valid ? nxt_word : '0;
            out_valid <= nxt_valid;
            ins_pulse <= (act == RA_INSERT);
            last_skip <= nxt_skip;
            if (!nxt_skip)
                run_len <= '0;
            else if (run_len != RUN_CAP)
                run_len <= run_len + RW'(1);
            if (act == RA_STARVE)
                unf_flag <= 1'b1;
            if (act == RA_POP) begin
                rbin  <= rbin_nxt;
                rgray <= rbin_nxt ^ (rbin_nxt >> 1);
                raddr <= (raddr == LAST_ADDR) ? '0 : raddr + AW'(1);
            end
        end
    end
endmodule

// File: rtl/clock_comp_ebuf.sv
`timescale 1ns/1ps
module clock_comp_ebuf
    import ccbuf_pkg::*;
#(
    parameter int DEPTH     = 20,
    parameter int HI_TH     = 14,
    parameter int LO_TH     = 6,
    parameter int START_LVL = 10,
    parameter int MAX_RUN   = 5
) (
    input  logic        wr_clk,
    input  logic        wr_rst,
    input  logic [17:0] wr_data,
    input  logic        rd_clk,
    input  logic        rd_rst,
    output logic [17:0] rd_data,
    output logic        rd_valid,
    input  logic        cfg_double,
    input  logic [7:0]  cfg_skip_sym,
    input  logic        cfg_skip_ctl,
    output logic        ins_pulse,
    output logic        del_pulse,
    output logic        ovf_flag,
    output logic        unf_flag
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam int RW = $clog2(MAX_RUN + 2);

    word_t         in_word;
    word_t         head;
    word_t         out_word;
    logic          we;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [PW-1:0] wgray;
    logic [PW-1:0] rgray;
    logic [PW-1:0] wptr_in_rd;
    logic [PW-1:0] rptr_in_wr;

    assign in_word = word_t'(wr_data);
    assign rd_data = 18'(out_word);

    ccbuf_ptr_sync #(.W(PW)) u_sync_w2r (
        .clk     (rd_clk),
        .rst     (rd_rst),
        .gray_in (wgray),
        .bin_out (wptr_in_rd)
    );

    ccbuf_ptr_sync #(.W(PW)) u_sync_r2w (
        .clk     (wr_clk),
        .rst     (wr_rst),
        .gray_in (rgray),
        .bin_out (rptr_in_wr)
    );

    ccbuf_wr_ctrl #(.DEPTH(DEPTH), .HI_TH(HI_TH), .AW(AW), .PW(PW)) u_wr (
        .wr_clk       (wr_clk),
        .wr_rst       (wr_rst),
        .in_word      (in_word),
        .cfg_double   (cfg_double),
        .cfg_skip_sym (cfg_skip_sym),
        .cfg_skip_ctl (cfg_skip_ctl),
        .rptr_bin     (rptr_in_wr),
        .we           (we),
        .waddr        (waddr),
        .wgray        (wgray),
        .del_pulse    (del_pulse),
        .ovf_flag     (ovf_flag)
    );

    ccbuf_store #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .wr_clk (wr_clk),
        .we     (we),
        .waddr  (waddr),
        .wdata  (in_word),
        .raddr  (raddr),
        .rdata  (head)
    );

    ccbuf_rd_ctrl #(
        .LO_TH(LO_TH), .START_LVL(START_LVL), .MAX_RUN(MAX_RUN),
        .DEPTH(DEPTH), .AW(AW), .PW(PW), .RW(RW)
    ) u_rd (
        .rd_clk       (rd_clk),
        .rd_rst       (rd_rst),
        .cfg_double   (cfg_double),
        .cfg_skip_sym (cfg_skip_sym),
        .cfg_skip_ctl (cfg_skip_ctl),
        .wptr_bin     (wptr_in_rd),
        .head         (head),
        .raddr        (raddr),
        .rgray        (rgray),
        .out_word     (out_word),
        .out_valid    (rd_valid),
        .ins_pulse    (ins_pulse),
        .unf_flag     (unf_flag)
    );
endmodule

// File: rtl/clock_comp_ebuf_chk.sv
`timescale 1ns/1ps
module clock_comp_ebuf_chk
    import ccbuf_pkg::*;
#(
    parameter int MAX_RUN = 5
) (
    input logic        wr_clk,
    input logic        wr_rst,
    input logic [17:0] wr_data,
    input logic        rd_clk,
    input logic        rd_rst,
    input logic [17:0] rd_data,
    input logic        rd_valid,
    input logic        cfg_double,
    input logic [7:0]  cfg_skip_sym,
    input logic        cfg_skip_ctl,
    input logic        ins_pulse,
    input logic        del_pulse,
    input logic        ovf_flag,
    input logic        unf_flag
);
    word_t wr_w;
    word_t rd_w;
    logic  wr_skip_single;
    logic  wr_skip_pair;
    logic  out_skip;
    logic  prev_skip;
    int    run_seen;

    assign wr_w           = word_t'(wr_data);
    assign rd_w           = word_t'(rd_data);
    assign wr_skip_single = word_is_skip(wr_w, 1'b0, cfg_skip_sym, cfg_skip_ctl);
    assign wr_skip_pair   = word_is_skip(wr_w, 1'b1, cfg_skip_sym, cfg_skip_ctl);
    assign out_skip       = rd_valid && word_is_skip(rd_w, cfg_double, cfg_skip_sym, cfg_skip_ctl);

    always_ff @(posedge rd_clk) begin
        if (rd_rst) begin
            prev_skip <= 1'b0;
            run_seen  <= 0;
        end else begin
            prev_skip <= out_skip;
            run_seen  <= out_skip ? ((run_seen < 1000) ? run_seen + 1 : run_seen) : 0;
        end
    end

    assert_del_single_R3: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (del_pulse && !cfg_double) |-> $past(wr_skip_single));

    assert_del_pair_R4: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (del_pulse && cfg_double) |-> $past(wr_skip_pair));

    assert_ins_after_skip_R5: assert property (@(posedge rd_clk) disable iff (rd_rst)
        ins_pulse |-> (out_skip && prev_skip));

    assert_run_cap_R6: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (ins_pulse && !cfg_double) |-> (run_seen < MAX_RUN));

    assert_ins_pair_R7: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (ins_pulse && cfg_double) |-> (rd_w.hi == rd_w.lo));

    assert_ovf_sticky_R8: assert property (@(posedge wr_clk) disable iff (wr_rst)
        ovf_flag |=> ovf_flag);

    assert_unf_sticky_R9: assert property (@(posedge rd_clk) disable iff (rd_rst)
        unf_flag |=> unf_flag);

    assert_upper_zero_R10: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_valid && !cfg_double) |-> (rd_w.hi == '0));
endmodule

bind clock_comp_ebuf clock_comp_ebuf_chk u_chk (.*);

// File: tb/sim_clock_comp_ebuf.sv
`timescale 1ns/1ps
module sim_clock_comp_ebuf;
    localparam int START_LVL = 10;
    localparam int MAX_RUN   = 5;

    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        wr_rst = 1'b1;
    logic        rd_rst = 1'b1;
    logic [17:0] wr_data = '0;
    logic [17:0] rd_data;
    logic        rd_valid;
    logic        cfg_double = 1'b0;
    logic [7:0]  cfg_skip_sym = 8'hF7;
    logic        cfg_skip_ctl = 1'b1;
    logic        ins_pulse, del_pulse, ovf_flag, unf_flag;

    real rd_half = 9.5;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int gen_mode = 0;      // 0 skip idle, 1 mixed, 2 data only
    bit cmp_en   = 1;
    int wr_cnt   = 0;
    int ins_cnt  = 0;
    int del_cnt  = 0;

    logic [17:0] exp_q [$];
    int          tag_q [$];

    always #10 wr_clk = ~wr_clk;
    always #(rd_half) rd_clk = ~rd_clk;

    clock_comp_ebuf u0 (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_data(wr_data),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_data(rd_data), .rd_valid(rd_valid),
        .cfg_double(cfg_double), .cfg_skip_sym(cfg_skip_sym), .cfg_skip_ctl(cfg_skip_ctl),
        .ins_pulse(ins_pulse), .del_pulse(del_pulse), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit lane_skip(input logic [8:0] l);
        return (l[7:0] == cfg_skip_sym) && (l[8] == cfg_skip_ctl);
    endfunction

    function automatic bit tb_skip(input logic [17:0] w);
        if (cfg_double) return lane_skip(w[17:9]) && lane_skip(w[8:0]);
        return lane_skip(w[8:0]);
    endfunction

    // Write stimulus, deletion monitor and reference queue
    initial begin
        int c = 0;
        logic [17:0] cur = '0;
        forever begin
            @(negedge wr_clk);
            if (!wr_rst && del_pulse) begin
                del_cnt++;
                chk(tb_skip(cur), cfg_double ? "R4 drop of non-pair" : "R3 drop of non-skip",
                    cur, {cfg_skip_ctl, cfg_skip_sym});
            end
            begin
                logic [8:0] sk;
                logic [8:0] dat;
                int idx;
                int tag;
                sk  = {cfg_skip_ctl, cfg_skip_sym};
                dat = {1'b0, c[7:0]};
                idx = c % 10;
                tag = 2;
                if (gen_mode == 0) cur = {sk, sk};
                else if (gen_mode == 2) cur = {1'b0, ~c[7:0], dat};
                else if (idx >= 7) cur = {cfg_double ? sk : {1'b0, ~c[7:0]}, sk};
                else if (idx == 3 && cfg_double) begin cur = {dat, sk}; tag = 4; end
                else if (idx == 5) begin
                    cur = {~cfg_skip_ctl, cfg_skip_sym, ~cfg_skip_ctl, cfg_skip_sym};
                    tag = 12;
                end
                else cur = {1'b0, ~c[7:0], dat};
                wr_data = cur;
                c++;
                if (!wr_rst) wr_cnt++;
                if (gen_mode != 0 && !tb_skip(cur)) begin
                    exp_q.push_back(cur);
                    tag_q.push_back(tag);
                end
            end
        end
    end

    // Read monitor
    initial begin
        bit primed_seen = 0;
        bit last_skip   = 0;
        int run         = 0;
        forever begin
            @(negedge rd_clk);
            if (rd_rst) begin
                primed_seen = 0; last_skip = 0; run = 0;
            end else begin
                if (rd_valid && !primed_seen) begin
                    primed_seen = 1;
                    chk(wr_cnt >= START_LVL, "R1 early start", wr_cnt, START_LVL);
                end
                if (ins_pulse) begin
                    ins_cnt++;
                    chk(last_skip && rd_valid && tb_skip(rd_data), "R5 insert not after skip",
                        rd_data, {cfg_skip_ctl, cfg_skip_sym});
                    if (cfg_double)
                        chk(rd_data[17:9] == rd_data[8:0], "R7 unpaired insert",
                            rd_data, {2{cfg_skip_ctl, cfg_skip_sym}});
                    else
                        chk(run + 1 <= MAX_RUN, "R6 skip run too long", run + 1, MAX_RUN);
                end
                if (rd_valid) begin
                    if (!cfg_double)
                        chk(rd_data[17:9] == 9'd0, "R10 upper lane", rd_data[17:9], 0);
                    if (tb_skip(rd_data)) begin
                        run++; last_skip = 1;
                    end else begin
                        run = 0; last_skip = 0;
                        if (cmp_en) begin
                            if (exp_q.size() == 0)
                                chk(0, "R2 unexpected word", rd_data, 0);
                            else begin
                                logic [17:0] e;
                                int t;
                                string r;
                                e = exp_q.pop_front();
                                t = tag_q.pop_front();
                                r = (t == 4) ? "R4 partial skip word" :
                                    (t == 12) ? "R12 flag mismatch word" : "R2 order";
                                if (cfg_double) chk(rd_data == e, r, rd_data, e);
                                else chk(rd_data[8:0] == e[8:0], r, rd_data[8:0], e[8:0]);
                            end
                        end
                    end
                end else if (primed_seen) begin
                    run = 0; last_skip = 0;
                    chk(unf_flag, "R9 idle without underflow", unf_flag, 1);
                end
            end
        end
    end

    task automatic do_reset(input logic dbl, input logic [7:0] sym);
        gen_mode = 0;
        repeat (4) @(negedge wr_clk);
        wr_rst = 1;
        @(negedge rd_clk);
        rd_rst = 1;
        cfg_double = dbl;
        cfg_skip_sym = sym;
        cfg_skip_ctl = 1'b1;
        repeat (6) @(negedge wr_clk);
        repeat (3) @(negedge rd_clk);
        chk(!rd_valid && !ins_pulse, "R11 read side reset", {rd_valid, ins_pulse}, 0);
        chk(!del_pulse && !ovf_flag && !unf_flag, "R11 flags reset",
            {del_pulse, ovf_flag, unf_flag}, 0);
        exp_q.delete();
        tag_q.delete();
        wr_cnt = 0; ins_cnt = 0; del_cnt = 0;
        @(negedge wr_clk);
        wr_rst = 0;
        @(negedge rd_clk);
        rd_rst = 0;
    endtask

    task automatic rate_phase(input logic dbl);
        cmp_en = 1;
        gen_mode = 1;
        rd_half = 9.5;
        repeat (1500) @(negedge wr_clk);
        chk(ins_cnt > 0, dbl ? "R7 no pair insertion seen" : "R5 no insertion seen", ins_cnt, 1);
        rd_half = 10.5;
        repeat (1500) @(negedge wr_clk);
        chk(del_cnt > 0, dbl ? "R4 no pair deletion seen" : "R3 no deletion seen", del_cnt, 1);
        chk(!ovf_flag, "R8 spurious overflow", ovf_flag, 0);
        chk(!unf_flag, "R9 spurious underflow", unf_flag, 0);
    endtask

    initial begin
        do_reset(1'b0, 8'hF7);
        rate_phase(1'b0);

        do_reset(1'b1, 8'h1C);
        rate_phase(1'b1);

        // overflow: slow reader, no skips to drop
        do_reset(1'b0, 8'hF7);
        rd_half = 20.0;
        cmp_en = 0;
        gen_mode = 2;
        repeat (200) @(negedge wr_clk);
        chk(ovf_flag, "R8 overflow not flagged", ovf_flag, 1);
        repeat (50) @(negedge wr_clk);
        chk(ovf_flag, "R8 overflow not sticky", ovf_flag, 1);

        // underflow: fast reader, nothing to repeat
        do_reset(1'b0, 8'hF7);
        chk(!ovf_flag, "R11 overflow cleared by reset", ovf_flag, 0);
        rd_half = 5.0;
        cmp_en = 1;
        gen_mode = 2;
        repeat (300) @(negedge wr_clk);
        @(negedge rd_clk);
        chk(unf_flag, "R9 underflow not flagged", unf_flag, 1);
        chk(ins_cnt == 0, "R5 insertion without skip", ins_cnt, 0);

        do_reset(1'b0, 8'hF7);
        chk(!unf_flag, "R11 underflow cleared by reset", unf_flag, 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge wr_clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired R2 actual=0 expected=1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule